// File: doc/BRIEF.md
# Translation service register file

This block is the software-visible control register file for the front end of an interrupt translation service. It holds the following state: a control word with the unit-enable bit, a read-only capability word and a fixed implementer ID, a command-queue base, a command write pointer, a command read pointer, and a parameterised bank of 64-bit table base registers. Software reaches all of it through a simple request/response bus. Every request carries a width flag that selects a 32-bit or a 64-bit access. The response comes back one cycle after the request, and an offset that is not decoded gets an error response.

Once the control write sets the enable bit, the block protects the configuration. The enable bit cannot be cleared. Writes to the queue base and to the table bases are dropped while the unit is enabled. An accepted queue-base write empties the queue by clearing both pointers. An external command engine steps the read pointer with a one-cycle pulse. The block exposes the enable state, the queue base and both pointers so that engine can read them.

Top module: `xlat_regfile`

## Requirements
- R1: Each request gets a response with `resp_valid` high exactly one cycle later, and with no request `resp_valid` is low the next cycle. A read returns the register contents from before that cycle's update. A write or error response returns zero data.
- R2: After reset, the control word, queue base, write pointer and read pointer are zero. The capability word at 0x008 reads the `TYPE_VAL` parameter and 0x004 reads `IMPL_ID`. Table n reads zero except its entry-size field (bits 52:48 = `ENT_SZ`) and its kind field (bits 58:56 = `TBL_TYPES[3n+2:3n]`).
- R3: The enable flag is bit 0 of the control word at 0x000, which supports 32-bit access only. A control write stores the old value OR the written value, so no bit can be cleared, and `unit_en` follows bit 0.
- R4: A control write after which bit 0 is set clears the read pointer. This clear takes precedence over a `cmd_done` pulse in the same cycle.
- R5: While `unit_en` is high, writes to the queue base and to every table base leave them unchanged and return no error.
- R6: An accepted write to the queue base clears the read pointer and the write pointer. This holds for a 32-bit write to the low half (0x080), a 32-bit write to the high half (0x084) and a 64-bit write.
- R7: The write pointer at 0x088 can be written at any time, and bit 0 always stores zero.
- R8: Table n sits at 0x100 + 8n. A 64-bit access to a table needs an 8-byte aligned address. In a 32-bit access, address bit 2 selects bits 63:32, and a 32-bit write changes only that half.
- R9: No write changes bits 52:48 or bits 58:56 of a table base.
- R10: Writes to the capability word (0x008), the read pointer (0x090), the ID code (0x004) and the 32-bit ID window 0xFFD0 to 0xFFFF are dropped without error. A read of the ID window returns zero without error.
- R11: These accesses get an error response and change no state: offsets that are not decoded, 32-bit accesses that are not 4-byte aligned, 64-bit accesses that are not 8-byte aligned, and 64-bit accesses to 0x000 or to the ID window.
- R12: A `cmd_done` pulse while `unit_en` is high adds one to read-pointer bits 19:5, which is one 32-byte entry. While the unit is disabled the pulse is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, one cycle per access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = 64-bit access, 0 = 32-bit access |
| req_addr | input | ADDR_W | Byte offset |
| req_wdata | input | 64 | Write data (bits 31:0 for a 32-bit access) |
| resp_valid | output | 1 | Response strobe, one cycle after the request |
| resp_err | output | 1 | Access not decoded |
| resp_rdata | output | 64 | Read data, zero-extended for a 32-bit access |
| cmd_done | input | 1 | Command engine consumed one queue entry |
| unit_en | output | 1 | Unit enabled |
| cq_base | output | 64 | Command-queue base register |
| cq_wptr | output | 64 | Command write pointer |
| cq_rptr | output | 64 | Command read pointer |

## Verification
The enable bit is sticky and only reset clears it. For this reason the run can visit the locked state only once. Every disabled-mode behaviour is exercised before the enabling write: table writes at both widths, both queue-base halves resetting the pointers, and `cmd_done` being ignored. After that write, the same writes are repeated and must have no effect. The hardest case to reach from the ports is a control write that lands on the same clock edge as a `cmd_done` pulse. The stimulus forces it by raising both inputs at one falling edge, and then checks that the read pointer has been cleared and not stepped.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

   typedef enum logic [3:0] {
      SEL_NONE, SEL_CTRL, SEL_IDCODE, SEL_TYPE, SEL_QBASE,
      SEL_WPTR, SEL_RPTR, SEL_TBL, SEL_IDWIN
   } sel_e;

   localparam int unsigned OFS_CTRL  = 'h000;
   localparam int unsigned OFS_TYPE  = 'h008;
   localparam int unsigned OFS_QBASE = 'h080;
   localparam int unsigned OFS_WPTR  = 'h088;
   localparam int unsigned OFS_RPTR  = 'h090;
   localparam int unsigned OFS_TBL   = 'h100;
   localparam int unsigned OFS_IDWIN = 'hFFD0;
   localparam int unsigned OFS_IDEND = 'h10000;

   // entry-size (52:48) and kind (58:56) fields of a table base
   localparam logic [63:0] TBL_RO_MASK = 64'h071F_0000_0000_0000;

   localparam int RPTR_LSB = 5;
   localparam int RPTR_MSB = 19;

   // half or full merge of write data, bits set in keep are preserved
   function automatic logic [63:0] merge_write(input logic [63:0] old,
                                               input logic [63:0] wd,
                                               input logic        wide,
                                               input logic        hi,
                                               input logic [63:0] keep);
      logic [63:0] n;
      if (wide)    n = wd;
      else if (hi) n = {wd[31:0], old[31:0]};
      else         n = {old[63:32], wd[31:0]};
      return (old & keep) | (n & ~keep);
   endfunction

endpackage

// File: rtl/xlat_decode.sv
module xlat_decode
   import xlat_pkg::*;
#(
   parameter int ADDR_W  = 16,
   parameter int NUM_TBL = 8,
   parameter int IDX_W   = 3
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              wide,
   output sel_e              sel,
   output logic              hi,
   output logic [IDX_W-1:0]  idx
);

   localparam int unsigned TBL_END = OFS_TBL + 8 * NUM_TBL;

   logic              aligned;
   logic [ADDR_W-1:0] dword;
   logic [ADDR_W:0]   addr_x;

   always_comb begin
      aligned = wide ? (addr[2:0] == 3'b000) : (addr[1:0] == 2'b00);
      dword   = {addr[ADDR_W-1:3], 3'b000};
      addr_x  = {1'b0, addr};
      hi      = !wide && addr[2];
      idx     = IDX_W'((addr - ADDR_W'(OFS_TBL)) >> 3);
      sel     = SEL_NONE;
      if (!aligned)
         sel = SEL_NONE;
      else if (addr >= ADDR_W'(OFS_TBL) && addr < ADDR_W'(TBL_END))
         sel = SEL_TBL;
      else if (dword == ADDR_W'(OFS_CTRL))
         sel = wide ? SEL_NONE : (addr[2] ? SEL_IDCODE : SEL_CTRL);
      else if (dword == ADDR_W'(OFS_TYPE))
         sel = SEL_TYPE;
      else if (dword == ADDR_W'(OFS_QBASE))
         sel = SEL_QBASE;
      else if (dword == ADDR_W'(OFS_WPTR))
         sel = SEL_WPTR;
      else if (dword == ADDR_W'(OFS_RPTR))
         sel = SEL_RPTR;
      else if (!wide && addr_x >= (ADDR_W+1)'(OFS_IDWIN) &&
               addr_x < (ADDR_W+1)'(OFS_IDEND))
         sel = SEL_IDWIN;
   end

endmodule

// File: rtl/xlat_tbl_bank.sv
module xlat_tbl_bank
   import xlat_pkg::*;
#(
   parameter int                   NUM_TBL   = 8,
   parameter int                   IDX_W     = 3,
   parameter logic [4:0]           ENT_SZ    = 5'd7,
   parameter logic [3*NUM_TBL-1:0] TBL_TYPES = 'h21
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [IDX_W-1:0] idx,
   input  logic             wide,
   input  logic             hi,
   input  logic [63:0]      wdata,
   output logic [63:0]      rdata
);

   logic [63:0] tbl [NUM_TBL];

   for (genvar i = 0; i < NUM_TBL; i++) begin : g_tbl
      localparam logic [63:0] PRELOAD =
         {5'b0, TBL_TYPES[3*i +: 3], 3'b0, ENT_SZ, 48'b0};
      logic [63:0] q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            q <= PRELOAD;
         else if (we && idx == IDX_W'(i))
            q <= merge_write(q, wdata, wide, hi, TBL_RO_MASK);
      end
      assign tbl[i] = q;
   end

   assign rdata = tbl[idx];

endmodule

// File: rtl/xlat_queue.sv
module xlat_queue
   import xlat_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        unit_en,
   input  logic        base_we,
   input  logic        wptr_we,
   input  logic        rptr_clr,
   input  logic        cmd_done,
   input  logic        wide,
   input  logic        hi,
   input  logic [63:0] wdata,
   output logic [63:0] base,
   output logic [63:0] wptr,
   output logic [63:0] rptr
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base <= '0;
         wptr <= '0;
         rptr <= '0;
      end else begin
         if (base_we)
            base <= merge_write(base, wdata, wide, hi, 64'd0);

         if (base_we)
            wptr <= '0;
         else if (wptr_we)
            wptr <= merge_write(wptr, wdata, wide, hi, 64'd0) & ~64'd1;

         if (base_we || rptr_clr)
            rptr <= '0;
         else if (cmd_done && unit_en)
            rptr[RPTR_MSB:RPTR_LSB] <= rptr[RPTR_MSB:RPTR_LSB] + 1'b1;
      end
   end

endmodule

// File: rtl/xlat_regfile.sv
module xlat_regfile
   import xlat_pkg::*;
#(
   parameter int                   ADDR_W    = 16,
   parameter int                   NUM_TBL   = 8,
   parameter logic [31:0]          IMPL_ID   = 32'h0210_A43B,
   parameter logic [63:0]          TYPE_VAL  = 64'h0000_000F_0007_1F01,
   parameter logic [4:0]           ENT_SZ    = 5'd7,
   parameter logic [3*NUM_TBL-1:0] TBL_TYPES = 'h21
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic              req_wide,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [63:0]       req_wdata,
   output logic              resp_valid,
   output logic              resp_err,
   output logic [63:0]       resp_rdata,
   input  logic              cmd_done,
   output logic              unit_en,
   output logic [63:0]       cq_base,
   output logic [63:0]       cq_wptr,
   output logic [63:0]       cq_rptr
);

   localparam int IDX_W = (NUM_TBL > 1) ? $clog2(NUM_TBL) : 1;

   if (ADDR_W < 16) begin : g_bad_addr
      $error("xlat_regfile: ADDR_W must be at least 16");
   end
   if (NUM_TBL < 1 || NUM_TBL > 64) begin : g_bad_tbl
      $error("xlat_regfile: NUM_TBL must be 1..64");
   end

   sel_e             sel;
   logic             hi;
   logic [IDX_W-1:0] idx;
   logic [31:0]      ctrl_q, ctrl_next;
   logic [63:0]      tbl_rdata, r64, rword;
   logic             hit, wr, ctrl_we, tbl_we, base_we, wptr_we, rptr_clr;

   xlat_decode #(.ADDR_W(ADDR_W), .NUM_TBL(NUM_TBL), .IDX_W(IDX_W)) u_dec (
      .addr (req_addr),
      .wide (req_wide),
      .sel  (sel),
      .hi   (hi),
      .idx  (idx)
   );

   assign hit       = req_valid && (sel != SEL_NONE);
   assign wr        = hit && req_write;
   assign ctrl_we   = wr && (sel == SEL_CTRL);
   assign ctrl_next = ctrl_q | req_wdata[31:0];
   assign tbl_we    = wr && (sel == SEL_TBL)   && !unit_en;
   assign base_we   = wr && (sel == SEL_QBASE) && !unit_en;
   assign wptr_we   = wr && (sel == SEL_WPTR);
   assign rptr_clr  = ctrl_we && ctrl_next[0];
   assign unit_en   = ctrl_q[0];

   always_ff @(posedge clk) begin
      if (!rst_n)       ctrl_q <= '0;
      else if (ctrl_we) ctrl_q <= ctrl_next;
   end

   xlat_tbl_bank #(
      .NUM_TBL(NUM_TBL), .IDX_W(IDX_W), .ENT_SZ(ENT_SZ), .TBL_TYPES(TBL_TYPES)
   ) u_tbl (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (tbl_we),
      .idx   (idx),
      .wide  (req_wide),
      .hi    (hi),
      .wdata (req_wdata),
      .rdata (tbl_rdata)
   );

   xlat_queue u_q (
      .clk      (clk),
      .rst_n    (rst_n),
      .unit_en  (unit_en),
      .base_we  (base_we),
      .wptr_we  (wptr_we),
      .rptr_clr (rptr_clr),
      .cmd_done (cmd_done),
      .wide     (req_wide),
      .hi       (hi),
      .wdata    (req_wdata),
      .base     (cq_base),
      .wptr     (cq_wptr),
      .rptr     (cq_rptr)
   );

   // control and ID code share one 8-byte slot, low and high half
   always_comb begin
      case (sel)
         SEL_CTRL, SEL_IDCODE: r64 = {IMPL_ID, ctrl_q};
         SEL_TYPE:             r64 = TYPE_VAL;
         SEL_QBASE:            r64 = cq_base;
         SEL_WPTR:             r64 = cq_wptr;
         SEL_RPTR:             r64 = cq_rptr;
         SEL_TBL:              r64 = tbl_rdata;
         default:              r64 = '0;
      endcase
      rword = req_wide ? r64 : {32'b0, hi ? r64[63:32] : r64[31:0]};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         resp_valid <= 1'b0;
         resp_err   <= 1'b0;
         resp_rdata <= '0;
      end else begin
         resp_valid <= req_valid;
         resp_err   <= req_valid && (sel == SEL_NONE);
         resp_rdata <= (hit && !req_write) ? rword : '0;
      end
   end

endmodule

module xlat_regfile_chk #(
   parameter int ADDR_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_write,
   input logic              req_wide,
   input logic [ADDR_W-1:0] req_addr,
   input logic              wd0,
   input logic              resp_valid,
   input logic              resp_err,
   input logic              unit_en,
   input logic [63:0]       cq_base,
   input logic              wptr0,
   input logic [63:0]       cq_rptr
);

   // R1
   resp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> resp_valid);

   // R1
   resp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !resp_valid);

   // R3
   en_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      unit_en |=> unit_en);

   // R4
   rptr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write && !req_wide && req_addr == '0 && (wd0 || unit_en))
      |=> (cq_rptr == 64'd0));

   // R5
   base_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      unit_en |=> $stable(cq_base));

   // R7
   wptr_retry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wptr0);

   // R11
   wide_ctrl_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_wide && req_addr == '0) |=> resp_err);

   // R12
   rptr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!unit_en && !req_valid) |=> $stable(cq_rptr));

endmodule

bind xlat_regfile xlat_regfile_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .req_write  (req_write),
   .req_wide   (req_wide),
   .req_addr   (req_addr),
   .wd0        (req_wdata[0]),
   .resp_valid (resp_valid),
   .resp_err   (resp_err),
   .unit_en    (unit_en),
   .cq_base    (cq_base),
   .wptr0      (cq_wptr[0]),
   .cq_rptr    (cq_rptr)
);

// File: tb/xlat_regfile_tb.sv
module xlat_regfile_tb;

   localparam logic [31:0] T_ID   = 32'h1357_2468;
   localparam logic [63:0] T_TYPE = 64'hA5A5_0000_1234_5678;
   localparam logic [63:0] RO     = 64'h071F_0000_0000_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0, req_wide = 1'b0;
   logic [15:0] req_addr = '0;
   logic [63:0] req_wdata = '0;
   logic        cmd_done = 1'b0;
   logic        resp_valid, resp_err, unit_en;
   logic [63:0] resp_rdata, cq_base, cq_wptr, cq_rptr;

   int total = 0;
   int bad   = 0;

   always #10 clk = ~clk;

   xlat_regfile #(
      .ADDR_W(16), .NUM_TBL(8), .IMPL_ID(T_ID), .TYPE_VAL(T_TYPE),
      .ENT_SZ(5'd3), .TBL_TYPES(24'hC00021)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_wide(req_wide), .req_addr(req_addr), .req_wdata(req_wdata),
      .resp_valid(resp_valid), .resp_err(resp_err), .resp_rdata(resp_rdata),
      .cmd_done(cmd_done), .unit_en(unit_en), .cq_base(cq_base),
      .cq_wptr(cq_wptr), .cq_rptr(cq_rptr)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic xfer(input bit w, input bit wide, input logic [15:0] a,
                       input logic [63:0] d, output logic [63:0] rd, output logic err);
      @(negedge clk);
      req_valid = 1'b1; req_write = w; req_wide = wide; req_addr = a; req_wdata = d;
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0;
      chk("R1 resp_valid", {63'd0, resp_valid}, 64'd1);
      rd  = resp_rdata;
      err = resp_err;
   endtask

   task automatic wr_ok(input bit wide, input logic [15:0] a, input logic [63:0] d, input string tag);
      logic [63:0] rd; logic err;
      xfer(1'b1, wide, a, d, rd, err);
      chk({tag, " write err"}, {63'd0, err}, 64'd0);
      chk({"R1 write data"}, rd, 64'd0);
   endtask

   task automatic rd_chk(input bit wide, input logic [15:0] a, input logic [63:0] exp, input string tag);
      logic [63:0] rd; logic err;
      xfer(1'b0, wide, a, 64'd0, rd, err);
      chk({tag, " read err"}, {63'd0, err}, 64'd0);
      chk(tag, rd, exp);
   endtask

   task automatic err_chk(input bit w, input bit wide, input logic [15:0] a, input string tag);
      logic [63:0] rd; logic err;
      xfer(w, wide, a, 64'hFFFF_FFFF_FFFF_FFFF, rd, err);
      chk({tag, " err"}, {63'd0, err}, 64'd1);
      chk({tag, " data"}, rd, 64'd0);
   endtask

   task automatic pulse_done(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); cmd_done = 1'b1;
         @(negedge clk); cmd_done = 1'b0;
      end
   endtask

   task automatic t_reset;
      @(negedge clk);
      chk("R1 idle resp", {63'd0, resp_valid}, 64'd0);
      chk("R2 unit_en", {63'd0, unit_en}, 64'd0);
      chk("R2 base", cq_base, 64'd0);
      chk("R2 wptr", cq_wptr, 64'd0);
      chk("R2 rptr", cq_rptr, 64'd0);
      rd_chk(1'b0, 16'h000, 64'd0, "R2 ctrl");
      rd_chk(1'b0, 16'h004, {32'd0, T_ID}, "R2 idcode");
      rd_chk(1'b1, 16'h008, T_TYPE, "R2 type");
      rd_chk(1'b0, 16'h00C, {32'd0, T_TYPE[63:32]}, "R2 type hi");
      rd_chk(1'b1, 16'h100, 64'h0103_0000_0000_0000, "R2 table0");
      rd_chk(1'b1, 16'h108, 64'h0403_0000_0000_0000, "R2 table1");
      rd_chk(1'b0, 16'h13C, 64'h0000_0000_0603_0000, "R2 table7 hi");
   endtask

   task automatic t_tables;
      wr_ok(1'b1, 16'h110, 64'hFFFF_FFFF_FFFF_FFFF, "R8 table2 wide");
      rd_chk(1'b1, 16'h110, 64'hF8E3_FFFF_FFFF_FFFF, "R9 table2 ro fields");
      wr_ok(1'b0, 16'h118, 64'h0000_0000_DEAD_BEEF, "R8 table3 lo");
      rd_chk(1'b1, 16'h118, 64'h0003_0000_DEAD_BEEF, "R8 table3 lo only");
      wr_ok(1'b0, 16'h11C, 64'd0, "R9 table3 hi zero");
      rd_chk(1'b1, 16'h118, 64'h0003_0000_DEAD_BEEF, "R9 table3 ro kept");
      wr_ok(1'b0, 16'h11C, 64'h0000_0000_FFFF_FFFF, "R8 table3 hi");
      rd_chk(1'b0, 16'h11C, 64'h0000_0000_F8E3_FFFF, "R8 table3 hi read");
      rd_chk(1'b0, 16'h118, 64'h0000_0000_DEAD_BEEF, "R8 table3 lo read");
      rd_chk(1'b1, 16'h110 - 16'h8, 64'h0403_0000_0000_0000, "R8 table1 untouched");
   endtask

   task automatic t_queue;
      wr_ok(1'b1, 16'h080, 64'h8000_0000_1234_5003, "R6 base wide");
      rd_chk(1'b1, 16'h080, 64'h8000_0000_1234_5003, "R6 base read");
      wr_ok(1'b1, 16'h088, 64'h0000_0000_0000_0121, "R7 wptr");
      rd_chk(1'b1, 16'h088, 64'h0000_0000_0000_0120, "R7 retry bit cleared");
      pulse_done(2);
      chk("R12 done ignored while disabled", cq_rptr, 64'd0);
      wr_ok(1'b0, 16'h084, 64'h0000_0000_8000_00FF, "R6 base hi");
      rd_chk(1'b1, 16'h088, 64'd0, "R6 wptr cleared by hi");
      rd_chk(1'b1, 16'h080, 64'h8000_00FF_1234_5003, "R6 base hi merged");
      wr_ok(1'b0, 16'h088, 64'h0000_0000_0000_0041, "R7 wptr lo");
      chk("R7 wptr port", cq_wptr, 64'h40);
      wr_ok(1'b0, 16'h080, 64'h0000_0000_0000_7000, "R6 base lo");
      chk("R6 wptr cleared by lo", cq_wptr, 64'd0);
      chk("R6 base lo merged", cq_base, 64'h8000_00FF_0000_7000);
      wr_ok(1'b0, 16'h088, 64'h61, "R7 wptr preset");
   endtask

   task automatic t_enable;
      wr_ok(1'b0, 16'h000, 64'h1, "R3 enable");
      chk("R3 unit_en", {63'd0, unit_en}, 64'd1);
      chk("R4 rptr after enable", cq_rptr, 64'd0);
      pulse_done(3);
      rd_chk(1'b1, 16'h090, 64'h60, "R12 rptr three steps");
      wr_ok(1'b0, 16'h000, 64'h0, "R3 clear attempt");
      chk("R3 enable sticky", {63'd0, unit_en}, 64'd1);
      rd_chk(1'b0, 16'h000, 64'h1, "R3 ctrl read");
      chk("R4 rptr cleared by ctrl write", cq_rptr, 64'd0);
      pulse_done(2);
      chk("R12 rptr two steps", cq_rptr, 64'h40);
      wr_ok(1'b1, 16'h080, 64'h1111, "R5 base locked");
      rd_chk(1'b1, 16'h080, 64'h8000_00FF_0000_7000, "R5 base unchanged");
      chk("R5 wptr unchanged", cq_wptr, 64'h60);
      chk("R5 rptr unchanged", cq_rptr, 64'h40);
      wr_ok(1'b1, 16'h110, 64'd0, "R5 table locked");
      rd_chk(1'b1, 16'h110, 64'hF8E3_FFFF_FFFF_FFFF, "R5 table unchanged");
      wr_ok(1'b1, 16'h088, 64'h0000_0000_000F_FFE1, "R7 wptr while enabled");
      chk("R7 wptr enabled value", cq_wptr, 64'h000F_FFE0);
      // control write on the same edge as a done pulse
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_wide = 1'b0;
      req_addr = 16'h000; req_wdata = 64'h2; cmd_done = 1'b1;
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0; cmd_done = 1'b0;
      chk("R4 clear beats done", cq_rptr, 64'd0);
      rd_chk(1'b0, 16'h000, 64'h3, "R3 ctrl or");
   endtask

   task automatic t_ro;
      pulse_done(1);
      wr_ok(1'b1, 16'h008, 64'd0, "R10 type write");
      rd_chk(1'b1, 16'h008, T_TYPE, "R10 type unchanged");
      wr_ok(1'b1, 16'h090, 64'hFFFF, "R10 rptr write");
      rd_chk(1'b1, 16'h090, 64'h20, "R10 rptr unchanged");
      wr_ok(1'b0, 16'h004, 64'h0, "R10 idcode write");
      rd_chk(1'b0, 16'h004, {32'd0, T_ID}, "R10 idcode unchanged");
      wr_ok(1'b0, 16'hFFD0, 64'h5A5A, "R10 idwin write");
      rd_chk(1'b0, 16'hFFD0, 64'd0, "R10 idwin read");
      rd_chk(1'b0, 16'hFFFC, 64'd0, "R10 idwin top");
   endtask

   task automatic t_err;
      err_chk(1'b0, 1'b0, 16'h0200, "R11 unmapped");
      err_chk(1'b1, 1'b1, 16'h0000, "R11 wide ctrl");
      err_chk(1'b0, 1'b0, 16'h0082, "R11 misaligned");
      err_chk(1'b0, 1'b0, 16'h0098, "R11 past rptr");
      err_chk(1'b0, 1'b1, 16'h011C, "R11 wide misaligned table");
      err_chk(1'b1, 1'b1, 16'hFFD0, "R11 wide idwin");
      err_chk(1'b0, 1'b0, 16'h0140, "R11 past tables");
      err_chk(1'b0, 1'b0, 16'hFFCC, "R11 below idwin");
      rd_chk(1'b0, 16'h000, 64'h3, "R11 ctrl untouched by error");
   endtask

   initial begin
      #(20 * 150000);
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset;
      t_tables;
      t_queue;
      t_enable;
      t_ro;
      t_err;
      repeat (2) @(negedge clk);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule